// File: doc/BRIEF.md
# Wraparound Burst Address Counter

This block produces the address sequence for a four-beat burst into a synchronous cache memory. A burst opens on any rising clock edge where either of two independent address strobes is high. One strobe comes from the processor side and one from the memory controller side. On that edge the block captures the full address bus. The upper bits are then frozen, and the lowest two bits become the starting point of a wrapping beat count.

After the burst opens, each rising edge with the advance input high moves to the next beat. With advance low, the position is held, which lets the requester insert wait states. The order of the low bits is chosen by an order-select input, sampled when the burst opens. The interleaved order XORs the start bits with the beat count. The linear order adds the beat count to the start bits, modulo four. The block drives the current full address and a flag that marks the fourth beat.

Top module: `wrap_burst_counter`

## Requirements
- R1: While rst_n is low, burst_addr is all zeros and last_beat is 0.
- R2: At a rising edge where ads_proc or ads_ctrl is 1, the block captures addr_in. After that edge burst_addr equals the captured address and last_beat is 0.
- R3: If order_sel was 0 when the burst opened (interleaved), the low two bits of burst_addr equal the captured low bits XOR the beat count.
- R4: If order_sel was 1 when the burst opened (linear), the low two bits of burst_addr equal the captured low bits plus the beat count, modulo 4.
- R5: Each rising edge with adv at 1 and both strobes at 0 raises the beat count by one. The count wraps from 3 to 0, so the fifth beat repeats the first address.
- R6: A rising edge with adv at 0 and both strobes at 0 leaves burst_addr and last_beat unchanged.
- R7: The bits of burst_addr above the low two change only on a strobe edge. Changes on addr_in without a strobe have no effect.
- R8: A strobe during a burst restarts it from the new addr_in at beat count 0, even when adv is 1 on the same edge.
- R9: order_sel is sampled only on a strobe edge. Changing it in the middle of a burst does not alter the order.
- R10: last_beat is 1 exactly when the beat count is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads_proc | input | 1 | Processor-side strobe that opens a burst |
| ads_ctrl | input | 1 | Controller-side strobe that opens a burst |
| adv | input | 1 | Step to the next beat |
| order_sel | input | 1 | 0 selects interleaved order, 1 selects linear order |
| addr_in | input | ADDR_W | Starting address |
| burst_addr | output | ADDR_W | Current beat address |
| last_beat | output | 1 | High on the fourth beat |

## Verification
The hardest situations to reach from the ports are those where events coincide. One is a strobe arriving on the same edge as adv during an unfinished burst. Another is order_sel or addr_in toggling mid-burst while adv is held low for several cycles. Directed sequences open bursts from each strobe in each order, run through the wrap, and reload mid-burst with adv high. Seeded random stimulus follows, with a low strobe probability so that long bursts with wait states occur. It also randomizes order_sel and addr_in on every cycle to cover the mid-burst changes.

// File: rtl/wrap_burst_pkg.sv
package wrap_burst_pkg;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

endpackage

// File: rtl/wrap_burst_state.sv
module wrap_burst_state
    import wrap_burst_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     step,
    input  logic [ADDR_W-1:0]        addr_in,
    input  burst_order_e             order_in,
    output logic [ADDR_W-CNT_W-1:0]  upper_q,
    output logic [CNT_W-1:0]         start_q,
    output logic [CNT_W-1:0]         cnt_q,
    output burst_order_e             order_q
);
    localparam int UP_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [UP_W-1:0]  upper;
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] cnt;
        burst_order_e     order;
    } state_t;

    state_t st_d, st_q;

    // Reload beats advance; otherwise hold.
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.upper = addr_in[ADDR_W-1:CNT_W];
            st_d.start = addr_in[CNT_W-1:0];
            st_d.cnt   = '0;
            st_d.order = order_in;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{upper: '0, start: '0, cnt: '0, order: ORD_INTERLEAVE};
        end else begin
            st_q <= st_d;
        end
    end

    assign upper_q = st_q.upper;
    assign start_q = st_q.start;
    assign cnt_q   = st_q.cnt;
    assign order_q = st_q.order;
endmodule

// File: rtl/wrap_burst_order.sv
module wrap_burst_order
    import wrap_burst_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_bits,
    input  logic [CNT_W-1:0] beat_cnt,
    input  burst_order_e     order,
    output logic [CNT_W-1:0] low_bits,
    output logic             final_beat
);
    logic [CNT_W-1:0] xor_bits;
    logic [CNT_W-1:0] sum_bits;

    always_comb begin
        xor_bits   = start_bits ^ beat_cnt;
        sum_bits   = start_bits + beat_cnt;
        low_bits   = (order == ORD_LINEAR) ? sum_bits : xor_bits;
        final_beat = &beat_cnt;
    end
endmodule

// File: rtl/wrap_burst_counter.sv
module wrap_burst_counter
    import wrap_burst_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_proc,
    input  logic              ads_ctrl,
    input  logic              adv,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              last_beat
);
    localparam int UP_W = ADDR_W - CNT_W;

    logic             load;
    logic [UP_W-1:0]  upper_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] cnt_q;
    burst_order_e     order_q;
    logic [CNT_W-1:0] low_bits;

    assign load = ads_proc | ads_ctrl;

    wrap_burst_state #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (adv),
        .addr_in  (addr_in),
        .order_in (burst_order_e'(order_sel)),
        .upper_q  (upper_q),
        .start_q  (start_q),
        .cnt_q    (cnt_q),
        .order_q  (order_q)
    );

    wrap_burst_order #(.CNT_W(CNT_W)) u_order (
        .start_bits (start_q),
        .beat_cnt   (cnt_q),
        .order      (order_q),
        .low_bits   (low_bits),
        .final_beat (last_beat)
    );

    assign burst_addr = {upper_q, low_bits};
endmodule

// File: rtl/wrap_burst_counter_chk.sv
module wrap_burst_counter_chk #(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ads_proc,
    input logic              ads_ctrl,
    input logic              adv,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] burst_addr,
    input logic              last_beat
);
    logic strobe;
    assign strobe = ads_proc | ads_ctrl;

    always_comb begin
        if (!rst_n) begin
            AST_RESET_ZERO: assert (burst_addr == '0 && !last_beat); // R1
        end
    end

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (burst_addr == $past(addr_in)) && !last_beat); // R2

    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && adv) |=> burst_addr[CNT_W-1:0] != $past(burst_addr[CNT_W-1:0])); // R5

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !adv) |=> $stable(burst_addr) && $stable(last_beat)); // R6

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(burst_addr[ADDR_W-1:CNT_W])); // R7

    AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && adv) |=> burst_addr == $past(addr_in)); // R8
endmodule

bind wrap_burst_counter wrap_burst_counter_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ads_proc   (ads_proc),
    .ads_ctrl   (ads_ctrl),
    .adv        (adv),
    .addr_in    (addr_in),
    .burst_addr (burst_addr),
    .last_beat  (last_beat)
);

// File: tb/wrap_burst_counter_tb.sv
module wrap_burst_counter_tb;
    localparam int AW = 18;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ads_proc = 1'b0, ads_ctrl = 1'b0, adv = 1'b0, order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] burst_addr;
    logic          last_beat;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Reference state
    logic [AW-CW-1:0] m_upper = '0;
    logic [CW-1:0]    m_start = '0;
    logic [CW-1:0]    m_cnt   = '0;
    logic             m_lin   = 1'b0;

    always #4 clk = ~clk;

    wrap_burst_counter #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ads_proc(ads_proc), .ads_ctrl(ads_ctrl),
        .adv(adv), .order_sel(order_sel), .addr_in(addr_in),
        .burst_addr(burst_addr), .last_beat(last_beat)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [CW-1:0] lo;
        lo = m_lin ? (m_start + m_cnt) : (m_start ^ m_cnt);
        return {m_upper, lo};
    endfunction

    function automatic logic exp_last();
        return m_cnt == 2'd3;
    endfunction

    task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(bit p, bit c, bit a, bit o, logic [AW-1:0] ad);
        ads_proc = p; ads_ctrl = c; adv = a; order_sel = o; addr_in = ad;
    endtask

    // One edge: update the reference from the driven inputs, then compare.
    task automatic tick(string req);
        @(posedge clk);
        if (ads_proc || ads_ctrl) begin
            m_upper = addr_in[AW-1:CW];
            m_start = addr_in[CW-1:0];
            m_cnt   = '0;
            m_lin   = order_sel;
        end else if (adv) begin
            m_cnt = m_cnt + 1'b1;
        end
        @(negedge clk);
        check(req, burst_addr, exp_addr());
        check({req, " R10"}, {{(AW-1){1'b0}}, last_beat}, {{(AW-1){1'b0}}, exp_last()});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        drive(0, 0, 1, 1, 18'h3_FFFF);
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check("R1", burst_addr, '0);
        check("R1", {{(AW-1){1'b0}}, last_beat}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 + R3: processor strobe, interleaved, start 01
        drive(1, 0, 0, 0, 18'h1_2341);
        tick("R2");
        drive(0, 0, 1, 0, 18'h0_0000);
        tick("R3"); tick("R3"); tick("R3");
        // R5: wrap back to the first address
        tick("R5");
        check("R5", burst_addr, 18'h1_2341);

        // R4: controller strobe, linear, start 01
        drive(0, 1, 0, 1, 18'h2_ABC5);
        tick("R2");
        drive(0, 0, 1, 1, 18'h0_0000);
        tick("R4");
        check("R4", burst_addr, 18'h2_ABC6);
        tick("R4");
        check("R4", burst_addr, 18'h2_ABC7);
        tick("R4");
        check("R4", burst_addr, 18'h2_ABC4);

        // R6 + R7: wait states with a moving address bus
        for (int i = 0; i < 4; i++) begin
            drive(0, 0, 0, i[0], 18'(i * 18'h1_1111));
            tick("R6");
            check("R7", burst_addr, 18'h2_ABC4);
        end

        // R9: order input flipped mid-burst
        drive(1, 0, 0, 0, 18'h0_0032);
        tick("R2");
        drive(0, 0, 1, 1, 18'h0_0000);
        tick("R9");
        check("R9", burst_addr, 18'h0_0033);
        tick("R9");
        check("R9", burst_addr, 18'h0_0030);

        // R8: strobe with adv high mid-burst
        drive(0, 1, 1, 1, 18'h3_0003);
        tick("R8");
        check("R8", burst_addr, 18'h3_0003);
        drive(1, 1, 1, 0, 18'h1_0002);
        tick("R8");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[3:0] == 4'd0, r[7:4] == 4'd0, r[9:8] != 2'd0, r[10], 18'($urandom));
            tick(r[9:8] != 2'd0 ? (m_lin ? "R4" : "R3") : "R6");
        end

        finish_run();
    end
endmodule